// File: doc/BRIEF.md
# Frame Boundary Tracker with Channel Position Decode

This block watches an 8 kHz frame pulse against an 8.192 MHz bit clock and marks the start of every 125 µs frame. The active level of the pulse comes from a configuration input, so the same logic serves sources that pulse low and sources that pulse high. The boundary is taken on the falling edge of the clock that finds the pulse at its active level. All state in the block updates on that falling edge.

Once the first boundary is seen, the block runs a counter of clock cycles within the frame. It emits a one-cycle strobe at each boundary, and it turns the count into the current backplane channel number and the bit offset within that channel. The decode covers two backplane frame formats: 256 channels per frame at 16.384 Mb/s, and 512 channels per frame at 32.768 Mb/s. A boundary that comes before the counter has reached the last cycle of the frame raises a sticky misalignment flag and restarts the count. Software clears the flag.

Top module: `frame_sync_top`

## Requirements
- R1: While reset is high at a falling clock edge, the outputs after that edge are: position 0, no strobe, misalignment flag 0, locked 0, active rate 0.
- R2: With polarity input 0, a low level on the pulse input is the active level. With polarity input 1, a high level is the active level. A pulse input held at its inactive level never produces a boundary.
- R3: A falling clock edge that samples the pulse input at its active level, after a sample at the inactive level, is a boundary. From that edge until the next falling edge, the strobe is 1, the position is 0 and locked is 1.
- R4: A pulse held active for several clock cycles produces one strobe only, on its first active sample.
- R5: While locked, the position rises by one at each falling edge. After the last cycle of the frame (CYCLES_PER_FRAME-1) it wraps to 0. A wrap without a pulse produces no strobe.
- R6: A boundary seen while locked, with the position not at CYCLES_PER_FRAME-1, sets the misalignment flag and restarts the position at 0. A boundary at the last position leaves the flag unchanged, and so does the first boundary after reset. Once set, the flag stays set.
- R7: The clear input, when sampled high, resets the misalignment flag. If a misaligned boundary comes at the same edge, the set takes priority.
- R8: With active rate 0 (16 Mb/s, four clock cycles per channel), the channel output is position/4 and the bit output is 2×(position mod 4).
- R9: With active rate 1 (32 Mb/s, two clock cycles per channel), the channel output is position/2 and the bit output is 4×(position mod 2).
- R10: The rate select input is captured only at a boundary. Between boundaries the active rate output and the channel decode do not change when rate select changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 8.192 MHz bit clock; all state updates on its falling edge |
| rst_i | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | 8 kHz frame pulse |
| fp_pol_i | input | 1 | Pulse active level: 0 low, 1 high |
| rate_sel_i | input | 1 | Requested backplane rate: 0 16 Mb/s, 1 32 Mb/s |
| mis_clr_i | input | 1 | Clears the misalignment flag |
| frame_start_o | output | 1 | One-cycle boundary strobe |
| pos_o | output | $clog2(CYCLES_PER_FRAME) | Clock-cycle position within the frame |
| chan_o | output | $clog2(CYCLES_PER_FRAME)-1 | Current backplane channel |
| bit_o | output | 3 | Index of the first bit of the channel carried in the current clock cycle |
| rate_act_o | output | 1 | Rate in force for the current frame |
| misalign_o | output | 1 | Sticky misalignment flag |
| locked_o | output | 1 | Set once the first boundary has been seen |

## Verification
The bench builds the block with CYCLES_PER_FRAME set to 64 rather than the default 1024. A full frame then lasts 64 cycles, and every sequence in the bench can be stepped through cycle by cycle at low cost: aligned boundaries, early boundaries, wraps with no pulse, and rate changes in mid-frame. With 64 cycles the 16 Mb/s decode has 16 channels and the 32 Mb/s decode has 32 channels. Both decodes and the top of the channel range are reached in every frame.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

    typedef enum logic {
        RATE_16M = 1'b0,
        RATE_32M = 1'b1
    } line_rate_e;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_TRACK = 1'b1
    } track_state_e;

    // Event produced by the pulse stage for the tracking stage
    typedef struct packed {
        logic active;   // pulse at its active level this sample
        logic rise;     // first active sample after an inactive one
    } pulse_ev_t;

    // Normalise the raw pulse level to "1 means active"
    function automatic logic pulse_active(input logic level, input logic pol);
        return pol ? level : ~level;
    endfunction

endpackage

// File: rtl/fsync_edge_detect.sv
module fsync_edge_detect
    import fsync_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      fp_i,
    input  logic      fp_pol_i,
    output pulse_ev_t ev_o
);
    logic act_now;
    logic act_prev_q;

    assign act_now = pulse_active(fp_i, fp_pol_i);

    // Sampled on the falling edge: the boundary sits inside the pulse
    always_ff @(negedge clk_i) begin
        if (rst_i) act_prev_q <= 1'b0;
        else       act_prev_q <= act_now;
    end

    always_comb begin
        ev_o.active = act_now;
        ev_o.rise   = act_now & ~act_prev_q;
    end
endmodule

// File: rtl/fsync_frame_track.sv
module fsync_frame_track
    import fsync_pkg::*;
#(
    parameter int CYCLES_PER_FRAME = 1024,
    localparam int CNT_W = $clog2(CYCLES_PER_FRAME)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  pulse_ev_t        ev_i,
    input  logic             rate_sel_i,
    input  logic             mis_clr_i,
    output logic [CNT_W-1:0] pos_o,
    output logic             start_o,
    output logic             misalign_o,
    output logic             locked_o,
    output line_rate_e       rate_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES_PER_FRAME - 1);

    track_state_e     state_q;
    logic [CNT_W-1:0] pos_q;
    logic             start_q;
    logic             mis_q;
    line_rate_e       rate_q;
    logic             boundary;
    logic             early;

    // The active level alone is not enough: only the first active sample counts
    assign boundary = ev_i.rise & ev_i.active;
    assign early    = boundary && (state_q == ST_TRACK) && (pos_q != LAST);

    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            start_q <= 1'b0;
            mis_q   <= 1'b0;
            rate_q  <= RATE_16M;
        end else begin
            start_q <= boundary;
            if (boundary) begin
                state_q <= ST_TRACK;
                pos_q   <= '0;
                rate_q  <= line_rate_e'(rate_sel_i);
            end else if (state_q == ST_TRACK) begin
                pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
            end
            // set wins over clear
            if (early)          mis_q <= 1'b1;
            else if (mis_clr_i) mis_q <= 1'b0;
        end
    end

    assign pos_o      = pos_q;
    assign start_o    = start_q;
    assign misalign_o = mis_q;
    assign locked_o   = (state_q == ST_TRACK);
    assign rate_o     = rate_q;
endmodule

// File: rtl/fsync_slot_decode.sv
module fsync_slot_decode
    import fsync_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] pos_i,
    input  line_rate_e       rate_i,
    output logic [CNT_W-2:0] chan_o,
    output logic [2:0]       bit_o
);
    logic [CNT_W-2:0] chan16;
    logic [CNT_W-2:0] chan32;

    // 16 Mb/s: 4 clocks per channel, 2 bits per clock
    assign chan16 = {1'b0, pos_i[CNT_W-1:2]};
    // 32 Mb/s: 2 clocks per channel, 4 bits per clock
    assign chan32 = pos_i[CNT_W-1:1];

    always_comb begin
        if (rate_i == RATE_32M) begin
            chan_o = chan32;
            bit_o  = {pos_i[0], 2'b00};
        end else begin
            chan_o = chan16;
            bit_o  = {pos_i[1:0], 1'b0};
        end
    end
endmodule

// File: rtl/frame_sync_top.sv
module frame_sync_top
    import fsync_pkg::*;
#(
    parameter int CYCLES_PER_FRAME = 1024,
    localparam int CNT_W = $clog2(CYCLES_PER_FRAME)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             fp_i,
    input  logic             fp_pol_i,
    input  logic             rate_sel_i,
    input  logic             mis_clr_i,
    output logic             frame_start_o,
    output logic [CNT_W-1:0] pos_o,
    output logic [CNT_W-2:0] chan_o,
    output logic [2:0]       bit_o,
    output logic             rate_act_o,
    output logic             misalign_o,
    output logic             locked_o
);
    pulse_ev_t  ev;
    line_rate_e rate_q;

    fsync_edge_detect u_edge (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .fp_i     (fp_i),
        .fp_pol_i (fp_pol_i),
        .ev_o     (ev)
    );

    fsync_frame_track #(.CYCLES_PER_FRAME(CYCLES_PER_FRAME)) u_track (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ev_i       (ev),
        .rate_sel_i (rate_sel_i),
        .mis_clr_i  (mis_clr_i),
        .pos_o      (pos_o),
        .start_o    (frame_start_o),
        .misalign_o (misalign_o),
        .locked_o   (locked_o),
        .rate_o     (rate_q)
    );

    fsync_slot_decode #(.CNT_W(CNT_W)) u_dec (
        .pos_i  (pos_o),
        .rate_i (rate_q),
        .chan_o (chan_o),
        .bit_o  (bit_o)
    );

    assign rate_act_o = rate_q;
endmodule

// File: rtl/fsync_checks.sv
module fsync_checks #(
    parameter int CYCLES_PER_FRAME = 1024,
    localparam int CNT_W = $clog2(CYCLES_PER_FRAME)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             rate_sel_i,
    input logic             mis_clr_i,
    input logic             frame_start_o,
    input logic [CNT_W-1:0] pos_o,
    input logic [CNT_W-2:0] chan_o,
    input logic [2:0]       bit_o,
    input logic             rate_act_o,
    input logic             misalign_o,
    input logic             locked_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES_PER_FRAME - 1);
    localparam int CH16 = CYCLES_PER_FRAME / 4;

    // R3
    strobe_pos_zero_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        frame_start_o |-> (pos_o == '0) && locked_o);

    // R5
    pos_step_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        (locked_o && !frame_start_o) |->
            (pos_o == (($past(pos_o) == LAST) ? '0 : $past(pos_o) + 1'b1)));

    // R6
    mis_sticky_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        ($past(misalign_o) && !$past(mis_clr_i)) |-> misalign_o);

    // R6
    mis_only_at_strobe_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        $rose(misalign_o) |-> frame_start_o);

    // R10
    rate_hold_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        !frame_start_o |-> $stable(rate_act_o));

    // R10
    rate_capture_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        frame_start_o |-> (rate_act_o == $past(rate_sel_i)));

    // R8
    chan16_range_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        !rate_act_o |-> (int'(chan_o) < CH16) && !bit_o[0]);

    // R9
    bit32_align_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        rate_act_o |-> (bit_o[1:0] == 2'b00));
endmodule

bind frame_sync_top fsync_checks #(.CYCLES_PER_FRAME(CYCLES_PER_FRAME)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .rate_sel_i    (rate_sel_i),
    .mis_clr_i     (mis_clr_i),
    .frame_start_o (frame_start_o),
    .pos_o         (pos_o),
    .chan_o        (chan_o),
    .bit_o         (bit_o),
    .rate_act_o    (rate_act_o),
    .misalign_o    (misalign_o),
    .locked_o      (locked_o)
);

// File: tb/sim_frame_sync_top.sv
module sim_frame_sync_top;
    localparam int CLK_PERIOD = 122;
    localparam int FRAME = 64;
    localparam int CW = $clog2(FRAME);

    typedef struct packed {
        logic pol;
        logic rate;
        int   gap;
        logic mis;
    } vec_t;

    // pulse polarity, rate, cycles between two pulses, expected misalignment
    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 64, 1'b0},
        '{1'b1, 1'b0, 64, 1'b0},
        '{1'b0, 1'b1, 64, 1'b0},
        '{1'b1, 1'b1, 64, 1'b0},
        '{1'b0, 1'b0, 40, 1'b1},
        '{1'b1, 1'b1, 50, 1'b1}
    };

    logic          clk_i = 1'b0;
    logic          rst_i = 1'b1;
    logic          fp_i = 1'b1;
    logic          fp_pol_i = 1'b0;
    logic          rate_sel_i = 1'b0;
    logic          mis_clr_i = 1'b0;
    logic          frame_start_o;
    logic [CW-1:0] pos_o;
    logic [CW-2:0] chan_o;
    logic [2:0]    bit_o;
    logic          rate_act_o;
    logic          misalign_o;
    logic          locked_o;

    int n_chk = 0;
    int n_fail = 0;

    frame_sync_top #(.CYCLES_PER_FRAME(FRAME)) u0 (.*);

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive after the rising edge, look after the falling edge that samples it
    task automatic step(input logic act);
        @(posedge clk_i); #1;
        fp_i = fp_pol_i ? act : ~act;
        @(negedge clk_i); #1;
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        step(1'b0);
        step(1'b0);
        rst_i = 1'b0;
    endtask

    task automatic check_decode(input string req, input int pos, input logic rate);
        if (rate) begin
            check({req, " chan"}, int'(chan_o), pos / 2);
            check({req, " bit"}, int'(bit_o), 4 * (pos % 2));
        end else begin
            check({req, " chan"}, int'(chan_o), pos / 4);
            check({req, " bit"}, int'(bit_o), 2 * (pos % 4));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        rst_i = 1'b1;
        step(1'b0);
        check("R1 pos", int'(pos_o), 0);
        check("R1 strobe", int'(frame_start_o), 0);
        check("R1 misalign", int'(misalign_o), 0);
        check("R1 locked", int'(locked_o), 0);
        check("R1 rate", int'(rate_act_o), 0);
        rst_i = 1'b0;

        // table walk: R2 R3 R5 R6 R8 R9
        foreach (VECS[i]) begin
            fp_pol_i   = VECS[i].pol;
            rate_sel_i = VECS[i].rate;
            do_reset();
            step(1'b1);
            check("R2 R3 strobe", int'(frame_start_o), 1);
            check("R3 pos", int'(pos_o), 0);
            check("R3 locked", int'(locked_o), 1);
            check("R10 rate", int'(rate_act_o), int'(VECS[i].rate));
            for (int k = 1; k < VECS[i].gap; k++) begin
                step(1'b0);
                if (k == 13 || k == 14) begin
                    check("R5 pos", int'(pos_o), k);
                    check_decode(VECS[i].rate ? "R9" : "R8", k, VECS[i].rate);
                end
            end
            step(1'b1);
            check("R3 strobe 2", int'(frame_start_o), 1);
            check("R6 pos restart", int'(pos_o), 0);
            check("R6 misalign", int'(misalign_o), int'(VECS[i].mis));
        end

        // R2 inactive level never locks
        fp_pol_i = 1'b1;
        do_reset();
        for (int k = 0; k < 10; k++) step(1'b0);
        check("R2 no lock high-active", int'(locked_o), 0);
        fp_pol_i = 1'b0;
        do_reset();
        for (int k = 0; k < 10; k++) step(1'b0);
        check("R2 no lock low-active", int'(locked_o), 0);

        // R4 held pulse
        do_reset();
        step(1'b1);
        step(1'b1);
        check("R4 single strobe", int'(frame_start_o), 0);
        check("R4 pos", int'(pos_o), 1);
        step(1'b1);
        check("R4 still no strobe", int'(frame_start_o), 0);

        // R5 wrap without pulse
        do_reset();
        step(1'b1);
        for (int k = 1; k < FRAME; k++) step(1'b0);
        check("R5 last", int'(pos_o), FRAME - 1);
        step(1'b0);
        check("R5 wrap pos", int'(pos_o), 0);
        check("R5 wrap no strobe", int'(frame_start_o), 0);
        step(1'b0);
        check("R5 after wrap", int'(pos_o), 1);

        // R6 R7 sticky flag and clear
        do_reset();
        step(1'b1);
        for (int k = 1; k < 10; k++) step(1'b0);
        step(1'b1);
        check("R6 set", int'(misalign_o), 1);
        for (int k = 0; k < 5; k++) step(1'b0);
        check("R6 sticky", int'(misalign_o), 1);
        mis_clr_i = 1'b1;
        step(1'b0);
        mis_clr_i = 1'b0;
        check("R7 clear", int'(misalign_o), 0);
        mis_clr_i = 1'b1;
        step(1'b1);
        mis_clr_i = 1'b0;
        check("R7 set beats clear", int'(misalign_o), 1);

        // R10 rate change mid-frame
        rate_sel_i = 1'b0;
        do_reset();
        step(1'b1);
        for (int k = 1; k < 6; k++) step(1'b0);
        rate_sel_i = 1'b1;
        step(1'b0);
        check("R10 rate held", int'(rate_act_o), 0);
        check_decode("R10 R8", 6, 1'b0);
        for (int k = 7; k < FRAME; k++) step(1'b0);
        step(1'b1);
        check("R10 rate taken", int'(rate_act_o), 1);
        check("R10 aligned", int'(misalign_o), 0);
        for (int k = 1; k <= 7; k++) step(1'b0);
        check_decode("R10 R9", 7, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule